// File: doc/BRIEF.md
# Remote Shutdown Delay and Fault Latch

This controller turns a remote power request and two digital protection flags into a single converter-inhibit output. The remote request is active-high for "supply off". A request that drives the converter off is applied after a short delay. A request that lets the converter run is applied after a longer delay. Both delays are counted in pulses of a fixed-rate tick input. If the request changes back before its delay expires, the pending change is dropped and the counter starts again from zero.

Over-voltage and under-voltage flags come from external comparators. Either flag sets a fault latch, and the latch holds the converter off. The latch clears only when the delayed remote state goes to "off". So after a fault shutdown the remote request must go to off and then back to on before the converter runs again. Under-voltage flags are masked for a blanking window that starts when the delayed remote state enables the supply. This lets the outputs rise without tripping the latch. The interface has only plain control and status pins: there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rsd_shutdown_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no tick yet, `inhibit` = 1, `remote_dly` = 1 and `fault_latched` = 0.
- R2: While `remote_off_req` is 1 and `remote_dly` is 0, `remote_dly` and `inhibit` rise at the clock edge that samples the ON_TICKS-th tick of that request, and not before. Cycles without a tick never change `remote_dly`.
- R3: While `remote_off_req` is 0 and `remote_dly` is 1, `remote_dly` falls at the clock edge that samples the OFF_TICKS-th tick of that request. With no fault latched, `inhibit` falls at the same edge.
- R4: A request excursion that returns to the current `remote_dly` level before its delay completes leaves `remote_dly` and `inhibit` unchanged. It also discards the ticks already counted, so the next excursion again needs the full delay.
- R5: `ovp_flag` = 1 sampled while `remote_dly` = 0 sets `fault_latched` at the next edge, whether or not under-voltage blanking is active.
- R6: `uvp_flag` = 1 sampled after the blanking window has ended sets `fault_latched` at the next edge.
- R7: The blanking window lasts for the first BLANK_TICKS ticks after `remote_dly` falls. During that window `uvp_flag` has no effect on `fault_latched` or `inhibit`. The window restarts on every enable.
- R8: Once set, `fault_latched` stays 1 while `remote_dly` is 0. It clears at the edge after `remote_dly` has been sampled as 1.
- R9: Clearing wins over setting. Fault flags sampled while `remote_dly` = 1 never set `fault_latched`.
- R10: `inhibit` is 1 whenever `fault_latched` or `remote_dly` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse; all delays count these |
| remote_off_req | input | 1 | Synchronised remote request, 1 = supply off (tie high when unused) |
| ovp_flag | input | 1 | Over-voltage fault flag |
| uvp_flag | input | 1 | Under-voltage fault flag |
| inhibit | output | 1 | 1 = converter held off |
| fault_latched | output | 1 | Fault latch state |
| remote_dly | output | 1 | Delayed remote state, 1 = off |

## Verification
`remote_dly` changes at the same edge that samples the completing tick, and `inhibit` follows it in that cycle with no extra register. The bench therefore samples one falling edge after each tick pulse. A fault flag shows on `fault_latched` one edge after it is sampled. A latch clear also shows one edge after `remote_dly` rises. For these cases the bench issues the completing tick by hand and checks the state before and after that single extra edge. This confirms the exact one-cycle lag rather than only the final state. Every input is driven on falling edges, so each check has a whole half period of settled outputs.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  // Width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef struct packed {
    logic ov;
    logic uv;
  } fault_t;
endpackage

// File: rtl/rsd_remote_filter.sv
module rsd_remote_filter #(
  parameter int unsigned ON_TICKS  = 8,
  parameter int unsigned OFF_TICKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_i,
  output logic dly_o
);
  localparam int unsigned MAXD = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int unsigned CW   = rsd_pkg::cnt_w(MAXD);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] OFF_LIM = CW'(OFF_TICKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          dly;

  // the delay length depends on the direction of the pending change
  assign limit = req_i ? ON_LIM : OFF_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly <= 1'b1;
      cnt <= '0;
    end else if (req_i == dly) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == limit) begin
        dly <= req_i;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dly_o = dly;
endmodule

// File: rtl/rsd_uv_blank.sv
module rsd_uv_blank #(
  parameter int unsigned BLANK_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_off_i,
  output logic mask_o
);
  generate
    if (BLANK_TICKS == 0) begin : g_none
      assign mask_o = 1'b0;
    end else begin : g_cnt
      localparam int unsigned CW = rsd_pkg::cnt_w(BLANK_TICKS);
      localparam logic [CW-1:0] LIM = CW'(BLANK_TICKS - 1);
      logic [CW-1:0] cnt;
      logic          mask;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask <= 1'b1;
          cnt  <= '0;
        end else if (supply_off_i) begin
          mask <= 1'b1;
          cnt  <= '0;
        end else if (mask && tick) begin
          if (cnt == LIM) begin
            mask <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end

      assign mask_o = mask;
    end
  endgenerate
endmodule

// File: rtl/rsd_fault_latch.sv
module rsd_fault_latch (
  input  logic            clk,
  input  logic            rst_n,
  input  rsd_pkg::fault_t flt_i,
  input  logic            uv_mask_i,
  input  logic            clr_i,
  output logic            q_o
);
  logic set;
  logic q;

  assign set = flt_i.ov | (flt_i.uv & ~uv_mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set)   q <= 1'b1;
  end

  assign q_o = q;
endmodule

// File: rtl/rsd_shutdown_ctrl.sv
module rsd_shutdown_ctrl #(
  parameter int unsigned ON_TICKS    = 8,
  parameter int unsigned OFF_TICKS   = 24,
  parameter int unsigned BLANK_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic remote_off_req,
  input  logic ovp_flag,
  input  logic uvp_flag,
  output logic inhibit,
  output logic fault_latched,
  output logic remote_dly
);
  rsd_pkg::fault_t flt;
  logic            uv_mask;
  logic            dly;
  logic            latch_q;

  assign flt.ov = ovp_flag;
  assign flt.uv = uvp_flag;

  rsd_remote_filter #(
    .ON_TICKS (ON_TICKS),
    .OFF_TICKS(OFF_TICKS)
  ) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .req_i(remote_off_req),
    .dly_o(dly)
  );

  rsd_uv_blank #(
    .BLANK_TICKS(BLANK_TICKS)
  ) u_blank (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .supply_off_i(dly),
    .mask_o      (uv_mask)
  );

  rsd_fault_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_i    (flt),
    .uv_mask_i(uv_mask),
    .clr_i    (dly),
    .q_o      (latch_q)
  );

  assign remote_dly    = dly;
  assign fault_latched = latch_q;
  assign inhibit       = latch_q | dly;
endmodule

// File: rtl/rsd_shutdown_chk.sv
module rsd_shutdown_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic ovp_flag,
  input logic inhibit,
  input logic fault_latched,
  input logic remote_dly
);
  // R10
  latch_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> inhibit);

  // R10
  remote_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_dly |-> inhibit);

  // R2
  dly_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(remote_dly));

  // R5
  ovp_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_flag && !remote_dly) |=> fault_latched);

  // R8
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !remote_dly) |=> fault_latched);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_dly |=> !fault_latched);
endmodule

bind rsd_shutdown_ctrl rsd_shutdown_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .ovp_flag     (ovp_flag),
  .inhibit      (inhibit),
  .fault_latched(fault_latched),
  .remote_dly   (remote_dly)
);

// File: tb/sim_rsd_shutdown_ctrl.sv
module sim_rsd_shutdown_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ON_T  = 3;
  localparam int OFF_T = 5;
  localparam int BLK_T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic remote_off_req = 1'b1;
  logic ovp_flag = 1'b0;
  logic uvp_flag = 1'b0;
  logic inhibit, fault_latched, remote_dly;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsd_shutdown_ctrl #(.ON_TICKS(ON_T), .OFF_TICKS(OFF_T), .BLANK_TICKS(BLK_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .remote_off_req(remote_off_req),
    .ovp_flag(ovp_flag), .uvp_flag(uvp_flag), .inhibit(inhibit),
    .fault_latched(fault_latched), .remote_dly(remote_dly)
  );

  task automatic chk(input string req, input logic e_inh, input logic e_lat, input logic e_dly);
    checks++;
    if (inhibit !== e_inh || fault_latched !== e_lat || remote_dly !== e_dly) begin
      errors++;
      $display("FAIL %s: inh/lat/dly actual %b%b%b expected %b%b%b",
               req, inhibit, fault_latched, remote_dly, e_inh, e_lat, e_dly);
    end
  endtask

  // one tick cycle followed by one idle cycle
  task automatic tk(input int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic go_off;
    remote_off_req = 1'b1; tk(ON_T);
  endtask

  task automatic go_on;
    remote_off_req = 1'b0; tk(OFF_T);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", 1, 0, 1);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 after reset", 1, 0, 1);

    // R3: enable, count ticks one by one
    remote_off_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no tick no change", 1, 0, 1);
    for (int k = 1; k <= OFF_T; k++) begin
      tk(1);
      if (k < OFF_T) chk("R3 before off delay", 1, 0, 1);
      else           chk("R3 release at off delay", 0, 0, 0);
    end

    // R7: uvp ignored during blanking, R6: trips after it
    uvp_flag = 1'b1;
    for (int k = 1; k < BLK_T; k++) begin
      tk(1);
      chk("R7 uvp blanked", 0, 0, 0);
    end
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R7 uvp blanked at last tick edge", 0, 0, 0);
    @(negedge clk);
    chk("R6 uvp after blanking", 1, 1, 0);
    uvp_flag = 1'b0;

    // R8: latch holds while remote stays on
    tk(OFF_T + 2);
    chk("R8 latch holds", 1, 1, 0);
    remote_off_req = 1'b1;
    tk(ON_T - 1);
    chk("R8 latch holds before delayed off", 1, 1, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R8 delayed off, latch not yet clear", 1, 1, 1);
    @(negedge clk);
    chk("R8 latch cleared", 1, 0, 1);

    // R9: faults while delayed remote is off
    ovp_flag = 1'b1; uvp_flag = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 clear wins", 1, 0, 1);
    ovp_flag = 1'b0; uvp_flag = 1'b0;
    @(negedge clk);
    chk("R9 clear wins after flags", 1, 0, 1);

    // R4: short low excursions while off
    for (int len = 0; len < OFF_T; len++) begin
      remote_off_req = 1'b0; tk(len);
      remote_off_req = 1'b1; tk(1);
      chk("R4 short low pulse", 1, 0, 1);
    end
    // restart: needs the full off delay again
    go_on;
    chk("R4 full off delay after aborts", 0, 0, 0);

    // R7: blanking restarts each enable; short uvp during window
    uvp_flag = 1'b1; @(negedge clk); uvp_flag = 1'b0;
    chk("R7 uvp blanked after re-enable", 0, 0, 0);

    // R4: short high excursions while on
    for (int len = 0; len < ON_T; len++) begin
      remote_off_req = 1'b1; tk(len);
      remote_off_req = 1'b0; tk(1);
      chk("R4 short high pulse", 0, 0, 0);
    end

    // R5: ovp sets latch in one edge, blank irrelevant
    go_off; go_on;
    ovp_flag = 1'b1; @(negedge clk); ovp_flag = 1'b0;
    chk("R5 ovp sets latch during blank", 1, 1, 0);
    go_off; go_on;
    tk(BLK_T);
    ovp_flag = 1'b1; @(negedge clk); ovp_flag = 1'b0;
    chk("R5 ovp sets latch after blank", 1, 1, 0);

    // R2: turn-off delay counted tick by tick; R10 inhibit follows
    remote_off_req = 1'b1;
    for (int k = 1; k <= ON_T; k++) begin
      tk(1);
      if (k < ON_T) chk("R2 before on delay (latched)", 1, 1, 0);
      else          chk("R2 delayed off, R10 latch clears", 1, 0, 1);
    end
    go_on;
    chk("R10 inhibit low when both clear", 0, 0, 0);
    remote_off_req = 1'b1;
    for (int k = 1; k <= ON_T; k++) begin
      tk(1);
      if (k < ON_T) chk("R2 before on delay", 0, 0, 0);
      else          chk("R2 inhibit at on delay", 1, 0, 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule